// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a virtual page against an in-memory hashed page table. The caller presents a 24-bit virtual segment identifier and a 32-bit effective address. The walker derives a hash from the segment identifier and the page index, and reads candidate 8-byte table entries over a simple word/byte memory master port. It scans the primary group of eight entries first. If that group has no match, it scans the secondary group. The secondary group is addressed by the complemented hash.

On a hit, the walker returns the entry's byte address, both entry words as they were read, and the translated real address. It also returns whether write permission can be granted yet. Before it responds, it marks the entry as referenced and, for a store, as changed. Each mark is a single-byte write into the entry, with no locking. On a miss, the response flag reports it.

Table placement comes from two configuration inputs, a base address and an offset mask. Permission decoding beyond the changed-bit rule is left to the caller.

Top module: `hpt_walker`

## Requirements
- R1: After synchronous reset, and until a lookup is accepted, `busy`, `mem_req` and `rsp_valid` are low.
- R2: The primary hash is the segment identifier XOR the page index, where the page index is address bits 27:12. The first read of a lookup goes to `cfg_base + ((hash * 64) AND cfg_mask)`. Entry slots are read in ascending order at steps of 8 bytes.
- R3: An entry's first word matches when all of these hold: bit 31 (valid) is 1, bit 6 (hash-select) equals the pass (0 primary, 1 secondary), bits 30:7 equal the segment identifier, and bits 5:0 equal address bits 27:22.
- R4: A word-aligned read of the first word (entry offset 0) always comes before any read of the second word (entry offset 4). The second word is read only for the entry that matched.
- R5: The secondary group uses the bitwise complement of the primary hash in the R2 formula. It is searched only when no primary slot matches. A primary match takes precedence. If neither group matches, the response carries `rsp_hit` = 0 and no write is issued.
- R6: When bit 8 (referenced) of the second word is 0, the walker issues a byte write to entry offset 6. The data is second-word bits 15:8 OR 0x01, carried on `mem_wdata[7:0]`.
- R7: When bit 7 (changed) of the second word is 0 and the access is a store, the walker issues a byte write to entry offset 7. The data is second-word bits 7:0 OR 0x80. This write comes after any R6 write. `rsp_write_ok` is 1 when the changed bit was already set or the access is a store, and 0 otherwise.
- R8: On a hit, the response returns the entry byte address and both words as read. The real address is second-word bits 31:12 joined with effective-address bits 11:0.
- R9: Only one memory transfer is outstanding at a time. A transfer completes in a cycle where both `mem_req` and `mem_ack` are high, and address, direction and data are held until then.
- R10: A request raised while `busy` is high is ignored: it does not change the ongoing walk or its response, and no walk follows it. `rsp_valid` pulses for one cycle, in which `busy` is already low, so a request in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request, taken when idle |
| req_vsid | input | 24 | Virtual segment identifier |
| req_ea | input | 32 | Effective address |
| req_store | input | 1 | Access is a store |
| cfg_base | input | 32 | Table base byte address |
| cfg_mask | input | 32 | Group offset mask |
| busy | output | 1 | Walk in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | An entry matched |
| rsp_ent_addr | output | 32 | Byte address of matched entry |
| rsp_word0 | output | 32 | First word of matched entry |
| rsp_word1 | output | 32 | Second word as read |
| rsp_real_addr | output | 32 | Translated address |
| rsp_write_ok | output | 1 | Write permission may be granted |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_byte | output | 1 | Transfer is a single byte |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write byte in bits 7:0 |
| mem_ack | input | 1 | Transfer completes this cycle |
| mem_rdata | input | 32 | Read word, valid with ack |

## Verification
The response strobe and the acceptance of the next lookup fall in the same cycle, because the walker returns to idle as it raises `rsp_valid`. The bench provokes this on every lookup of its sweeps by driving the next request in the very cycle the response is observed. Each following walk is judged by its full memory-transfer sequence and its response fields, which must match a reference walk computed from the table contents. A second collision is a request that arrives in the middle of a walk. That case is judged by the undisturbed result of the walk in progress and by a quiet memory port afterwards.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    // entry geometry (behavioural: offsets decoded by the byte updates)
    localparam int WORD_W     = 32;
    localparam int PTE_BYTES  = 8;
    localparam int PTE_SHIFT  = 3;
    localparam int W1_OFF     = 4;
    localparam int R_BYTE_OFF = 6;
    localparam int C_BYTE_OFF = 7;

    // first word fields
    localparam int V_BIT = 31;
    localparam int H_BIT = 6;

    // second word fields
    localparam int R_BIT = 8;
    localparam int C_BIT = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_RD1,
        ST_SETR,
        ST_SETC
    } walk_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] w0;
        logic [WORD_W-1:0] w1;
    } pte_t;

    function automatic logic [7:0] ref_set_byte(input logic [7:0] b);
        return b | 8'h01;
    endfunction

    function automatic logic [7:0] chg_set_byte(input logic [7:0] b);
        return b | 8'h80;
    endfunction

endpackage

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
    import hpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VSID_W = 24,
    parameter int PIDX_W = 16,
    parameter int WAYS   = 8,
    localparam int IDX_W     = $clog2(WAYS),
    localparam int GRP_SHIFT = $clog2(WAYS * PTE_BYTES)
) (
    input  logic [VSID_W-1:0] vsid,
    input  logic [PIDX_W-1:0] pidx,
    input  logic              pass,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] entry_addr
);
    logic [ADDR_W-1:0] hash_p;
    logic [ADDR_W-1:0] hash_sel;
    logic [ADDR_W-1:0] grp_off;
    logic [ADDR_W-1:0] slot_off;

    always_comb begin
        hash_p     = ADDR_W'(vsid) ^ ADDR_W'(pidx);
        hash_sel   = pass ? ~hash_p : hash_p;
        grp_off    = (hash_sel << GRP_SHIFT) & mask;
        slot_off   = ADDR_W'(idx) << PTE_SHIFT;
        entry_addr = base + grp_off + slot_off;
    end
endmodule

// File: rtl/hpt_pte_match.sv
module hpt_pte_match
    import hpt_pkg::*;
#(
    parameter int VSID_W = 24,
    parameter int API_W  = 6
) (
    input  logic [WORD_W-1:0] w0,
    input  logic [VSID_W-1:0] vsid,
    input  logic [API_W-1:0]  api,
    input  logic              pass,
    output logic              hit
);
    localparam logic [WORD_W-1:0] CMP_MASK =
        ~((WORD_W'(1) << V_BIT) | (WORD_W'(1) << H_BIT));

    logic [WORD_W-1:0] cmp_val;

    always_comb begin
        cmp_val = (WORD_W'(vsid) << (H_BIT + 1)) | WORD_W'(api);
        hit     = w0[V_BIT] && (w0[H_BIT] == pass)
                  && (((w0 ^ cmp_val) & CMP_MASK) == '0);
    end
endmodule

// File: rtl/hpt_rc_update.sv
module hpt_rc_update
    import hpt_pkg::*;
(
    input  logic [15:0] w1_lo,
    input  logic        store,
    output logic        need_r,
    output logic        need_c,
    output logic [7:0]  r_data,
    output logic [7:0]  c_data,
    output logic        write_ok
);
    always_comb begin
        need_r   = !w1_lo[R_BIT];
        need_c   = !w1_lo[C_BIT] && store;
        r_data   = ref_set_byte(w1_lo[15:8]);
        c_data   = chg_set_byte(w1_lo[7:0]);
        write_ok = w1_lo[C_BIT] || store;
    end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VSID_W = 24,
    parameter int WAYS   = 8,
    parameter int POFF_W = 12,
    parameter int SEG_W  = 4,
    localparam int PIDX_W = ADDR_W - SEG_W - POFF_W,
    localparam int API_W  = PIDX_W - 10,
    localparam int IDX_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VSID_W-1:0] req_vsid,
    input  logic [ADDR_W-1:0] req_ea,
    input  logic              req_store,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_mask,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [ADDR_W-1:0] rsp_ent_addr,
    output logic [WORD_W-1:0] rsp_word0,
    output logic [WORD_W-1:0] rsp_word1,
    output logic [ADDR_W-1:0] rsp_real_addr,
    output logic              rsp_write_ok,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam logic [ADDR_W-1:0] POFF_MASK = (ADDR_W'(1) << POFF_W) - 1'b1;
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(WAYS - 1);

    walk_state_e       st_q;
    logic [VSID_W-1:0] vsid_q;
    logic [ADDR_W-1:0] ea_q;
    logic [ADDR_W-1:0] ent_q;
    logic              store_q;
    logic              pass_q;
    logic              hit_q;
    logic [IDX_W-1:0]  idx_q;
    pte_t              pte_q;

    logic [PIDX_W-1:0] pidx;
    logic [API_W-1:0]  api;
    logic [ADDR_W-1:0] cur_addr;
    logic              rd_match;
    logic [15:0]       rc_w1_lo;
    logic              need_r;
    logic              need_c;
    logic [7:0]        r_data;
    logic [7:0]        c_data;
    logic              write_ok;
    logic              xfer;

    assign pidx = ea_q[ADDR_W-SEG_W-1:POFF_W];
    assign api  = pidx[PIDX_W-1 -: API_W];

    hpt_addr_gen #(
        .ADDR_W (ADDR_W),
        .VSID_W (VSID_W),
        .PIDX_W (PIDX_W),
        .WAYS   (WAYS)
    ) u_addr (
        .vsid       (vsid_q),
        .pidx       (pidx),
        .pass       (pass_q),
        .idx        (idx_q),
        .base       (cfg_base),
        .mask       (cfg_mask),
        .entry_addr (cur_addr)
    );

    hpt_pte_match #(
        .VSID_W (VSID_W),
        .API_W  (API_W)
    ) u_match (
        .w0   (mem_rdata),
        .vsid (vsid_q),
        .api  (api),
        .pass (pass_q),
        .hit  (rd_match)
    );

    // second word comes from the bus while it is being read, else from the hold register
    assign rc_w1_lo = (st_q == ST_RD1) ? mem_rdata[15:0] : pte_q.w1[15:0];

    hpt_rc_update u_rc (
        .w1_lo    (rc_w1_lo),
        .store    (store_q),
        .need_r   (need_r),
        .need_c   (need_c),
        .r_data   (r_data),
        .c_data   (c_data),
        .write_ok (write_ok)
    );

    // memory master: one transfer per state, held until acknowledged
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_byte  = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st_q)
            ST_RD0: begin
                mem_req  = 1'b1;
                mem_addr = cur_addr;
            end
            ST_RD1: begin
                mem_req  = 1'b1;
                mem_addr = ent_q + ADDR_W'(W1_OFF);
            end
            ST_SETR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_byte  = 1'b1;
                mem_addr  = ent_q + ADDR_W'(R_BYTE_OFF);
                mem_wdata = WORD_W'(r_data);
            end
            ST_SETC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_byte  = 1'b1;
                mem_addr  = ent_q + ADDR_W'(C_BYTE_OFF);
                mem_wdata = WORD_W'(c_data);
            end
            default: ;
        endcase
    end

    assign xfer = mem_req && mem_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            rsp_valid <= 1'b0;
            hit_q     <= 1'b0;
            vsid_q    <= '0;
            ea_q      <= '0;
            ent_q     <= '0;
            store_q   <= 1'b0;
            pass_q    <= 1'b0;
            idx_q     <= '0;
            pte_q     <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vsid_q  <= req_vsid;
                        ea_q    <= req_ea;
                        store_q <= req_store;
                        pass_q  <= 1'b0;
                        idx_q   <= '0;
                        hit_q   <= 1'b0;
                        st_q    <= ST_RD0;
                    end
                end
                ST_RD0: begin
                    if (xfer) begin
                        if (rd_match) begin
                            pte_q.w0 <= mem_rdata;
                            ent_q    <= cur_addr;
                            hit_q    <= 1'b1;
                            st_q     <= ST_RD1;
                        end else if (idx_q != LAST_IDX) begin
                            idx_q <= idx_q + 1'b1;
                        end else if (!pass_q) begin
                            pass_q <= 1'b1;
                            idx_q  <= '0;
                        end else begin
                            st_q      <= ST_IDLE;
                            rsp_valid <= 1'b1;
                        end
                    end
                end
                ST_RD1: begin
                    if (xfer) begin
                        pte_q.w1 <= mem_rdata;
                        if (need_r) begin
                            st_q <= ST_SETR;
                        end else if (need_c) begin
                            st_q <= ST_SETC;
                        end else begin
                            st_q      <= ST_IDLE;
                            rsp_valid <= 1'b1;
                        end
                    end
                end
                ST_SETR: begin
                    if (xfer) begin
                        if (need_c) begin
                            st_q <= ST_SETC;
                        end else begin
                            st_q      <= ST_IDLE;
                            rsp_valid <= 1'b1;
                        end
                    end
                end
                ST_SETC: begin
                    if (xfer) begin
                        st_q      <= ST_IDLE;
                        rsp_valid <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy          = (st_q != ST_IDLE);
    assign rsp_hit       = hit_q;
    assign rsp_ent_addr  = ent_q;
    assign rsp_word0     = pte_q.w0;
    assign rsp_word1     = pte_q.w1;
    assign rsp_real_addr = (ADDR_W'(pte_q.w1) & ~POFF_MASK) | (ea_q & POFF_MASK);
    assign rsp_write_ok  = hit_q && write_ok;

endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [ADDR_W-1:0] rsp_ent_addr,
    input logic [31:0]       rsp_word0,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_byte,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack
);
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9

    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R9

    AST_READ_WORD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (!mem_byte && mem_addr[1:0] == 2'b00)); // R4

    AST_WRITE_BYTE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_byte && mem_addr[2:1] == 2'b11)); // R6

    AST_REF_BIT_SET: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_addr[2:0] == 3'd6) |-> mem_wdata[0]); // R6

    AST_CHG_BIT_SET: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_addr[2:0] == 3'd7) |-> mem_wdata[7]); // R7

    AST_HIT_IS_VALID: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> (rsp_word0[31] && rsp_ent_addr[2:0] == 3'd0)); // R3

    AST_RSP_ENDS_WALK: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (!busy && $past(busy))); // R10

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R10
endmodule

bind hpt_walker hpt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_ent_addr (rsp_ent_addr),
    .rsp_word0    (rsp_word0),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_byte     (mem_byte),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack)
);

// File: tb/hpt_walker_test.sv
`timescale 1ns/1ps
module hpt_walker_test;
    localparam logic [31:0] BASE  = 32'h0000_1000;
    localparam logic [31:0] MASK  = 32'h0000_0FC0;
    localparam int          WORDS = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [23:0] req_vsid = '0;
    logic [31:0] req_ea = '0;
    logic        req_store = 1'b0;
    logic        busy, rsp_valid, rsp_hit, rsp_write_ok;
    logic [31:0] rsp_ent_addr, rsp_word0, rsp_word1, rsp_real_addr;
    logic        mem_req, mem_we, mem_byte;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    hpt_walker uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vsid(req_vsid),
        .req_ea(req_ea), .req_store(req_store), .cfg_base(BASE), .cfg_mask(MASK),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_ent_addr(rsp_ent_addr), .rsp_word0(rsp_word0), .rsp_word1(rsp_word1),
        .rsp_real_addr(rsp_real_addr), .rsp_write_ok(rsp_write_ok),
        .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    always #2.5 clk = ~clk;

    int errs = 0;
    int checks = 0;

    // bench-owned table (written only by the stimulus)
    logic [31:0] mem [0:WORDS-1];

    // responder with variable latency and a transfer log
    int          lat = 0;
    int          wait_cnt = 0;
    int          log_n = 0;
    int          oob = 0;
    int          hold_err = 0;
    logic        prev_pend = 1'b0;
    logic [31:0] prev_addr = '0;
    logic [31:0] log_addr [0:4095];
    logic        log_we   [0:4095];
    logic [7:0]  log_data [0:4095];

    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            wait_cnt  <= 0;
            prev_pend <= 1'b0;
        end else begin
            if (prev_pend && (!mem_req || mem_addr != prev_addr)) hold_err++;
            prev_pend <= mem_req && !mem_ack;
            prev_addr <= mem_addr;
            if (mem_req && !mem_ack) begin
                if (wait_cnt >= lat) begin
                    mem_ack  <= 1'b1;
                    wait_cnt <= 0;
                    log_addr[log_n] <= mem_addr;
                    log_we[log_n]   <= mem_we;
                    log_data[log_n] <= mem_wdata[7:0];
                    log_n <= log_n + 1;
                    if (!mem_we) begin
                        if (mem_addr >= BASE && mem_addr < BASE + 32'(WORDS * 4))
                            mem_rdata <= mem[(mem_addr - BASE) >> 2];
                        else begin
                            mem_rdata <= 32'hDEAD_BEEF;
                            oob++;
                        end
                    end
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- table helpers ----------------
    function automatic logic [31:0] rdm(input logic [31:0] a);
        return mem[(a - BASE) >> 2];
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < WORDS; i++) mem[i] = 32'h0;
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1);
        mem[(a - BASE) >> 2]     = w0;
        mem[((a - BASE) >> 2) + 1] = w1;
    endtask

    function automatic logic [31:0] slot_addr(input logic [23:0] v, input logic [31:0] ea,
                                              input bit pass, input int s);
        logic [31:0] h;
        h = {8'h0, v} ^ {16'h0, ea[27:12]};
        if (pass) h = ~h;
        return BASE + ((h << 6) & MASK) + 32'(s * 8);
    endfunction

    function automatic logic [31:0] mk_w0(input bit vld, input logic [23:0] v, input bit h, input logic [5:0] api);
        return {vld, v, h, api};
    endfunction

    function automatic logic [31:0] mk_w1(input logic [19:0] rpn, input bit r, input bit c);
        return {rpn, 3'b101, r, c, 5'b01010, 2'b10};
    endfunction

    function automatic logic [31:0] decoy(input int j, input logic [23:0] v, input logic [5:0] api, input bit pass);
        case (j % 4)
            0: return mk_w0(1'b0, v, pass, api);
            1: return mk_w0(1'b1, v, !pass, api);
            2: return mk_w0(1'b1, v, pass, api ^ 6'h01);
            default: return mk_w0(1'b1, v ^ 24'h800000, pass, api);
        endcase
    endfunction

    // ---------------- reference walk from the requirements ----------------
    int          exp_n;
    logic [31:0] exp_addr [0:31];
    logic        exp_we   [0:31];
    logic [7:0]  exp_data [0:31];
    bit          exp_hit, exp_wok;
    logic [31:0] exp_ent, exp_w0, exp_w1, exp_real;

    task automatic push(input logic [31:0] a, input bit we, input logic [7:0] d);
        exp_addr[exp_n] = a;
        exp_we[exp_n]   = we;
        exp_data[exp_n] = d;
        exp_n++;
    endtask

    task automatic ref_walk(input logic [23:0] v, input logic [31:0] ea, input bit st);
        logic [31:0] a, w0, w1;
        exp_n = 0;
        exp_hit = 0;
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 8; s++) begin
                if (!exp_hit) begin
                    a  = slot_addr(v, ea, p[0], s);
                    w0 = rdm(a);
                    push(a, 1'b0, 8'h00);
                    if (w0[31] && w0[6] == p[0] && w0[30:7] == v && w0[5:0] == ea[27:22]) begin
                        exp_hit = 1;
                        w1 = rdm(a + 4);
                        push(a + 4, 1'b0, 8'h00);
                        exp_ent  = a;
                        exp_w0   = w0;
                        exp_w1   = w1;
                        if (!w1[8]) push(a + 6, 1'b1, w1[15:8] | 8'h01);
                        if (!w1[7] && st) push(a + 7, 1'b1, w1[7:0] | 8'h80);
                        exp_wok  = w1[7] | st;
                        exp_real = {w1[31:12], ea[11:0]};
                    end
                end
            end
        end
    endtask

    // ---------------- lookup driving ----------------
    int log_start = 0;

    task automatic start_lookup(input logic [23:0] v, input logic [31:0] ea, input bit st);
        ref_walk(v, ea, st);
        log_start = log_n;
        req_valid = 1'b1;
        req_vsid  = v;
        req_ea    = ea;
        req_store = st;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_lookup(input string ctx);
        int cyc = 0;
        int n;
        string tg;
        while (!rsp_valid && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk(rsp_valid, {"R9 response timeout ", ctx}, 32'(cyc), 32'd2000);
        n = log_n - log_start;
        chk(n == exp_n, {"R5 transfer count ", ctx}, 32'(n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < n; i++) begin
            if (exp_we[i]) tg = (exp_addr[i][2:0] == 3'd6) ? "R6" : "R7";
            else if (exp_addr[i][2]) tg = "R4";
            else tg = (i < 8) ? "R2" : "R5";
            chk(log_addr[log_start + i] == exp_addr[i], {tg, " address ", ctx},
                log_addr[log_start + i], exp_addr[i]);
            chk(log_we[log_start + i] == exp_we[i], {tg, " direction ", ctx},
                32'(log_we[log_start + i]), 32'(exp_we[i]));
            if (exp_we[i])
                chk(log_data[log_start + i] == exp_data[i], {tg, " byte data ", ctx},
                    32'(log_data[log_start + i]), 32'(exp_data[i]));
        end
        chk(rsp_hit == exp_hit, {"R3 hit flag ", ctx}, 32'(rsp_hit), 32'(exp_hit));
        if (exp_hit) begin
            chk(rsp_ent_addr == exp_ent, {"R8 entry address ", ctx}, rsp_ent_addr, exp_ent);
            chk(rsp_word0 == exp_w0, {"R8 word0 ", ctx}, rsp_word0, exp_w0);
            chk(rsp_word1 == exp_w1, {"R8 word1 ", ctx}, rsp_word1, exp_w1);
            chk(rsp_real_addr == exp_real, {"R8 real address ", ctx}, rsp_real_addr, exp_real);
            chk(rsp_write_ok == exp_wok, {"R7 write permission ", ctx},
                32'(rsp_write_ok), 32'(exp_wok));
        end
    endtask

    task automatic lookup(input logic [23:0] v, input logic [31:0] ea, input bit st, input string ctx);
        start_lookup(v, ea, st);
        finish_lookup(ctx);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(5.0 * 150000);
        errs++;
        checks++;
        $display("FAIL R9 watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [23:0] v;
        logic [31:0] ea;
        logic [5:0]  api;
        int          quiet;
        clear_mem();
        repeat (4) @(negedge clk);
        chk(!busy && !mem_req && !rsp_valid, "R1 outputs during reset", {busy, mem_req, rsp_valid}, 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && !mem_req && !rsp_valid, "R1 outputs after reset", {busy, mem_req, rsp_valid}, 32'h0);

        // primary-group sweep: every slot, load and store, all R/C combinations
        for (int k = 0; k < 8; k++) begin
            for (int st = 0; st < 2; st++) begin
                logic [1:0] rc;
                clear_mem();
                lat = (k + st) % 3;
                v   = 24'h03A5C1 + 24'(k * 24'h001357 + st * 24'h0A0A0);
                ea  = {4'h5, 16'h2C40 + 16'(k * 16'h0421 + st * 16'h1111), 12'h9AB};
                api = ea[27:22];
                for (int j = 0; j < k; j++)
                    put(slot_addr(v, ea, 1'b0, j), decoy(j + st, v, api, 1'b0), mk_w1(20'hFFFFF, 1'b0, 1'b0));
                rc = 2'(k + st);
                put(slot_addr(v, ea, 1'b0, k), mk_w0(1'b1, v, 1'b0, api),
                    mk_w1(20'hA0000 + 20'(k), rc[1], rc[0]));
                lookup(v, ea, st[0], $sformatf("primary slot %0d store %0d", k, st));
            end
        end

        // secondary-group sweep: primary full of near-misses
        for (int k = 0; k < 8; k++) begin
            clear_mem();
            lat = k % 3;
            v   = 24'h71E200 ^ 24'(k * 24'h010203);
            ea  = {4'hA, 16'h8F10 ^ 16'(k * 16'h0C31), 12'h123};
            api = ea[27:22];
            for (int j = 0; j < 8; j++)
                put(slot_addr(v, ea, 1'b0, j), decoy(j, v, api, 1'b0), mk_w1(20'h11111, 1'b0, 1'b0));
            for (int j = 0; j < k; j++)
                put(slot_addr(v, ea, 1'b1, j), decoy(j + 1, v, api, 1'b1), mk_w1(20'h22222, 1'b0, 1'b0));
            put(slot_addr(v, ea, 1'b1, k), mk_w0(1'b1, v, 1'b1, api),
                mk_w1(20'h5B000 + 20'(k), k[1], k[0]));
            lookup(v, ea, k[2], $sformatf("secondary slot %0d", k));
        end

        // miss: both groups hold only near-misses
        clear_mem();
        lat = 1;
        v   = 24'h0F0F0F;
        ea  = 32'h3123_4567;
        api = ea[27:22];
        for (int j = 0; j < 8; j++) begin
            put(slot_addr(v, ea, 1'b0, j), decoy(j, v, api, 1'b0), mk_w1(20'h33333, 1'b0, 1'b0));
            put(slot_addr(v, ea, 1'b1, j), decoy(j + 2, v, api, 1'b1), mk_w1(20'h44444, 1'b0, 1'b0));
        end
        lookup(v, ea, 1'b1, "miss in both groups R5");

        // precedence: matches in both groups, primary must win
        clear_mem();
        lat = 0;
        v   = 24'hC0FFEE;
        ea  = 32'h7ABC_DEF0;
        api = ea[27:22];
        put(slot_addr(v, ea, 1'b0, 5), mk_w0(1'b1, v, 1'b0, api), mk_w1(20'h77777, 1'b1, 1'b0));
        put(slot_addr(v, ea, 1'b1, 0), mk_w0(1'b1, v, 1'b1, api), mk_w1(20'h88888, 1'b0, 1'b0));
        lookup(v, ea, 1'b0, "primary precedence R5");

        // request raised mid-walk is ignored
        clear_mem();
        lat = 3;
        v   = 24'h123456;
        ea  = 32'h0246_8ACE;
        api = ea[27:22];
        put(slot_addr(v, ea, 1'b0, 6), mk_w0(1'b1, v, 1'b0, api), mk_w1(20'h9ABCD, 1'b0, 1'b0));
        start_lookup(v, ea, 1'b1);
        repeat (5) @(negedge clk);
        req_valid = 1'b1;
        req_vsid  = 24'h654321;
        req_ea    = 32'hF000_0000;
        req_store = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        finish_lookup("request during busy R10");
        quiet = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (mem_req || busy) quiet++;
        end
        chk(quiet == 0, "R10 no walk after ignored request", 32'(quiet), 32'h0);

        chk(hold_err == 0, "R9 request held until acknowledge", 32'(hold_err), 32'h0);
        chk(oob == 0, "R2 reads stay inside table", 32'(oob), 32'h0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule